// File: doc/BRIEF.md
# Zoned Asynchronous External Bus Controller

This block connects an internal request port to an asynchronous external memory bus with separate address and data pins. Each request carries a 16-bit-word address. The block decodes that address into one of three fixed zones and drives the chip select of that zone, which is active low. It then runs the access in three phases: lead, strobe and trail. Each zone has its own programmable length for each phase. An external ready input can lengthen the strobe phase. Any zone can be set to a 16-bit or a 32-bit data path. In 32-bit mode, address bit 0 becomes the write strobe for the upper half of the data bus.

Requests enter on a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the controller is idle and the bus is not being requested or held by another master. The requester must keep `req_valid` and the request fields stable until the request is taken. Each request that is taken produces exactly one `rsp_valid` pulse one cycle long. That pulse cannot be back-pressured, so the requester must be able to take it at any time. An external master can take over the bus with a hold request. The controller first finishes any access already in progress. It then releases its pins for one cycle, and only after that does it raise hold acknowledge.

Top module: `zbus_ctrl`

## Requirements
- R1: The address decodes into three zones: index 0 covers 0x004000–0x004FFF, index 1 covers 0x100000–0x1FFFFF and index 2 covers 0x200000–0x2FFFFF. Any other address is unmapped. Bit i of `ext_cs_n` and the i-th CW-bit slice of each `cfg_*` bus belong to zone index i.
- R2: At most one chip select is low at any time. A chip select is low only during the lead, strobe and trail phases of an access to its own zone. All chip selects are high after reset.
- R3: The lead phase lasts max(lead,1) cycles. During it the chip select and `ext_addr` (request address bits 19:1) are driven and every strobe is high.
- R4: The strobe phase lasts at least max(active,1) cycles. After that minimum it continues for every cycle in which `ext_ready` is sampled low, so with ready low for the first K strobe cycles its length is max(max(active,1), K+1).
- R5: The trail phase lasts max(trail,1) cycles. During it all strobes are high and the chip select stays low. The response pulse follows on the next cycle, when the chip select is already high.
- R6: Read data is captured on the last strobe cycle. A zone in 16-bit mode returns `ext_data_i[15:0]` zero-extended. A zone in 32-bit mode returns all 32 bits. A write returns zero.
- R7: In a zone whose `cfg_wide` bit is 0, `ext_a0_wehi_n` carries request address bit 0 for the whole access. A write drives `ext_we_n` low through the strobe phase and places `req_wdata[15:0]` on the low data lanes.
- R8: In a zone whose `cfg_wide` bit is 1, during a write strobe `ext_we_n` is low when `req_hwen[0]` is 1 and `ext_a0_wehi_n` is low when `req_hwen[1]` is 1. Outside a write strobe both are high.
- R9: An unmapped request gives `rsp_valid` with `rsp_err`=1 and `rsp_rdata`=0 on the cycle after it is taken. No chip select and no strobe moves.
- R10: When `ext_hold_req` is high in the idle state, `ext_bus_oe` goes low one cycle later and `ext_hold_ack` rises one cycle after that. `ext_hold_ack` falls one cycle after `ext_hold_req` goes low. If the hold request arrives during an access, that access completes before the bus is released.
- R11: `req_ready` is low during any access and whenever `ext_hold_req` or `ext_hold_ack` is high. It is high after reset.
- R12: `ext_rnw` is low and `ext_data_oe` is high for the whole of a write access. During a read `ext_rnw` is high and `ext_data_oe` is low. `ext_rd_n` and `ext_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 22 | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_hwen | input | 2 | Half-word enables for 32-bit writes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request hit no zone |
| rsp_rdata | output | DW | Read data |
| cfg_lead | input | 3*CW | Lead-phase count for each zone |
| cfg_active | input | 3*CW | Minimum strobe-phase count for each zone |
| cfg_trail | input | 3*CW | Trail-phase count for each zone |
| cfg_wide | input | 3 | 32-bit data path for each zone |
| ext_addr | output | EAW-1 | External address bits 19:1 |
| ext_a0_wehi_n | output | 1 | Address bit 0, or upper write strobe in 32-bit mode |
| ext_cs_n | output | 3 | Chip selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Lower-half write strobe, active low |
| ext_rnw | output | 1 | Direction: 1 = read |
| ext_data_o | output | DW | Write data to the pads |
| ext_data_oe | output | 1 | Drive enable for the data pads |
| ext_data_i | input | DW | Data from the pads |
| ext_ready | input | 1 | External ready, low stretches the strobe phase |
| ext_bus_oe | output | 1 | Low when address and control pins are released |
| ext_hold_req | input | 1 | External bus hold request |
| ext_hold_ack | output | 1 | Hold acknowledge |

## Verification
The hardest case to reach is a hold request that arrives while an access is in progress. It collides with the ready stretch and with the order of trail, response and release. To create it, the bench raises the hold request on the first lead cycle of an access that also has ready held low. It then checks three things: the access runs all its phases to normal length, the response appears while the bus is still driven, and the bus is released and then acknowledged only on the two following cycles. Exact ready timing is the other hard part. The bench drops ready for a chosen number of strobe cycles, measured from where the strobe first goes low, so that the stall both lands inside and runs past the programmed minimum.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
  localparam int NZ   = 3;
  localparam int IA_W = 22;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_TRAIL,
    ST_REL,
    ST_GRANT
  } zst_t;

  function automatic logic [IA_W-1:0] zone_base(input int idx);
    case (idx)
      0:       return 22'h004000;
      1:       return 22'h100000;
      default: return 22'h200000;
    endcase
  endfunction

  function automatic logic [IA_W-1:0] zone_span(input int idx);
    case (idx)
      0:       return 22'h001000;
      default: return 22'h100000;
    endcase
  endfunction
endpackage

// File: rtl/zbus_zone_dec.sv
module zbus_zone_dec
  import zbus_pkg::*;
(
  input  logic [IA_W-1:0] addr,
  output logic [NZ-1:0]   hit_oh,
  output logic            hit
);
  for (genvar g = 0; g < NZ; g++) begin : g_zone
    logic [IA_W-1:0] lo;
    logic [IA_W-1:0] hi;
    assign lo        = zone_base(g);
    assign hi        = zone_base(g) + zone_span(g);
    assign hit_oh[g] = (addr >= lo) && (addr < hi);
  end
  assign hit = |hit_oh;
endmodule

// File: rtl/zbus_phase_cnt.sv
module zbus_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? CW'(1) : load_val;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt <= CW'(1));
endmodule

// File: rtl/zbus_pin_map.sv
module zbus_pin_map
  import zbus_pkg::*;
#(
  parameter int DW  = 32,
  parameter int EAW = 20
) (
  input  logic           busy,
  input  logic           in_act,
  input  logic           wr,
  input  logic           wide,
  input  logic [1:0]     hwen,
  input  logic [EAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NZ-1:0]  zone,
  output logic [EAW-2:0] ext_addr,
  output logic           ext_a0_wehi_n,
  output logic [NZ-1:0]  ext_cs_n,
  output logic           ext_rd_n,
  output logic           ext_we_n,
  output logic           ext_rnw,
  output logic [DW-1:0]  ext_data_o,
  output logic           ext_data_oe
);
  localparam int HW = DW / 2;

  logic we_lo;
  logic we_hi;

  assign we_lo = in_act && wr && (wide ? hwen[0] : 1'b1);
  assign we_hi = in_act && wr && wide && hwen[1];

  assign ext_addr      = addr[EAW-1:1];
  assign ext_a0_wehi_n = wide ? ~we_hi : addr[0];
  assign ext_cs_n      = ~(zone & {NZ{busy}});
  assign ext_rd_n      = ~(in_act && !wr);
  assign ext_we_n      = ~we_lo;
  assign ext_rnw       = busy ? ~wr : 1'b1;
  assign ext_data_oe   = busy && wr;
  assign ext_data_o    = wide ? wdata : {{(DW-HW){1'b0}}, wdata[HW-1:0]};
endmodule

// File: rtl/zbus_ctrl.sv
module zbus_ctrl
  import zbus_pkg::*;
#(
  parameter int CW  = 4,
  parameter int DW  = 32,
  parameter int EAW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IA_W-1:0]  req_addr,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  input  logic [1:0]       req_hwen,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [NZ*CW-1:0] cfg_lead,
  input  logic [NZ*CW-1:0] cfg_active,
  input  logic [NZ*CW-1:0] cfg_trail,
  input  logic [NZ-1:0]    cfg_wide,
  output logic [EAW-2:0]   ext_addr,
  output logic             ext_a0_wehi_n,
  output logic [NZ-1:0]    ext_cs_n,
  output logic             ext_rd_n,
  output logic             ext_we_n,
  output logic             ext_rnw,
  output logic [DW-1:0]    ext_data_o,
  output logic             ext_data_oe,
  input  logic [DW-1:0]    ext_data_i,
  input  logic             ext_ready,
  output logic             ext_bus_oe,
  input  logic             ext_hold_req,
  output logic             ext_hold_ack
);
  localparam int HW = DW / 2;

  zst_t           st;
  logic [NZ-1:0]  zone_q;
  logic [EAW-1:0] addr_q;
  logic           wr_q;
  logic           wide_q;
  logic [1:0]     hwen_q;
  logic [DW-1:0]  wdata_q;

  logic [NZ-1:0]  dec_oh;
  logic           dec_hit;
  logic [CW-1:0]  lead_sel;
  logic [CW-1:0]  act_sel;
  logic [CW-1:0]  trl_sel;
  logic           wide_sel;
  logic           accept;
  logic           ph_last;
  logic           ph_load;
  logic [CW-1:0]  ph_val;
  logic           busy;
  logic           in_act;

  zbus_zone_dec u_dec (
    .addr   (req_addr),
    .hit_oh (dec_oh),
    .hit    (dec_hit)
  );

  always_comb begin
    lead_sel = '0;
    act_sel  = '0;
    trl_sel  = '0;
    wide_sel = 1'b0;
    for (int i = 0; i < NZ; i++) begin
      if (dec_oh[i]) begin
        lead_sel = lead_sel | cfg_lead[i*CW +: CW];
        wide_sel = wide_sel | cfg_wide[i];
      end
      if (zone_q[i]) begin
        act_sel = act_sel | cfg_active[i*CW +: CW];
        trl_sel = trl_sel | cfg_trail[i*CW +: CW];
      end
    end
  end

  assign req_ready = (st == ST_IDLE) && !ext_hold_req;
  assign accept    = req_valid && req_ready;
  assign busy      = (st == ST_LEAD) || (st == ST_ACT) || (st == ST_TRAIL);
  assign in_act    = (st == ST_ACT);

  always_comb begin
    ph_load = 1'b0;
    ph_val  = lead_sel;
    case (st)
      ST_IDLE: begin
        ph_load = accept && dec_hit;
        ph_val  = lead_sel;
      end
      ST_LEAD: begin
        ph_load = ph_last;
        ph_val  = act_sel;
      end
      ST_ACT: begin
        ph_load = ph_last && ext_ready;
        ph_val  = trl_sel;
      end
      default: begin
        ph_load = 1'b0;
        ph_val  = trl_sel;
      end
    endcase
  end

  zbus_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      zone_q    <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      hwen_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (ext_hold_req) begin
            st <= ST_REL;
          end else if (req_valid) begin
            if (dec_hit) begin
              st      <= ST_LEAD;
              zone_q  <= dec_oh;
              addr_q  <= req_addr[EAW-1:0];
              wr_q    <= req_write;
              wide_q  <= wide_sel;
              hwen_q  <= req_hwen;
              wdata_q <= req_wdata;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end
          end
        end
        ST_LEAD: begin
          if (ph_last) st <= ST_ACT;
        end
        ST_ACT: begin
          if (ph_last && ext_ready) begin
            st <= ST_TRAIL;
            if (wr_q)        rsp_rdata <= '0;
            else if (wide_q) rsp_rdata <= ext_data_i;
            else             rsp_rdata <= {{(DW-HW){1'b0}}, ext_data_i[HW-1:0]};
          end
        end
        ST_TRAIL: begin
          if (ph_last) begin
            st        <= ST_IDLE;
            zone_q    <= '0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
          end
        end
        ST_REL: begin
          st <= ST_GRANT;
        end
        ST_GRANT: begin
          if (!ext_hold_req) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ext_bus_oe   = (st != ST_REL) && (st != ST_GRANT);
  assign ext_hold_ack = (st == ST_GRANT);

  zbus_pin_map #(.DW(DW), .EAW(EAW)) u_pins (
    .busy          (busy),
    .in_act        (in_act),
    .wr            (wr_q),
    .wide          (wide_q),
    .hwen          (hwen_q),
    .addr          (addr_q),
    .wdata         (wdata_q),
    .zone          (zone_q),
    .ext_addr      (ext_addr),
    .ext_a0_wehi_n (ext_a0_wehi_n),
    .ext_cs_n      (ext_cs_n),
    .ext_rd_n      (ext_rd_n),
    .ext_we_n      (ext_we_n),
    .ext_rnw       (ext_rnw),
    .ext_data_o    (ext_data_o),
    .ext_data_oe   (ext_data_oe)
  );
endmodule

// File: rtl/zbus_ctrl_chk.sv
module zbus_ctrl_chk
  import zbus_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata,
  input logic [NZ-1:0] ext_cs_n,
  input logic          ext_rd_n,
  input logic          ext_we_n,
  input logic          ext_rnw,
  input logic          ext_data_oe,
  input logic          ext_bus_oe,
  input logic          ext_hold_req,
  input logic          ext_hold_ack
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ext_cs_n) <= 1); // R2
  AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_n |-> (ext_cs_n != '1)); // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_we_n |-> (ext_cs_n != '1)); // R2
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_we_n)); // R12
  AST_OE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> !ext_rnw); // R12
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (ext_cs_n == '1)); // R9
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R9
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hold_ack |-> (ext_cs_n == '1 && !ext_bus_oe)); // R10
  AST_ACK_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_hold_ack) |-> !$past(ext_bus_oe)); // R10
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hold_ack && !ext_hold_req) |=> !ext_hold_ack); // R10
  AST_NO_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hold_ack |-> !req_ready); // R11
endmodule

bind zbus_ctrl zbus_ctrl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .ext_cs_n     (ext_cs_n),
  .ext_rd_n     (ext_rd_n),
  .ext_we_n     (ext_we_n),
  .ext_rnw      (ext_rnw),
  .ext_data_oe  (ext_data_oe),
  .ext_bus_oe   (ext_bus_oe),
  .ext_hold_req (ext_hold_req),
  .ext_hold_ack (ext_hold_ack)
);

// File: tb/tb_zbus_ctrl.sv
module tb_zbus_ctrl;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam int EAW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [21:0]    req_addr = '0;
  logic           req_write = 1'b0;
  logic [DW-1:0]  req_wdata = '0;
  logic [1:0]     req_hwen = '0;
  logic           rsp_valid;
  logic           rsp_err;
  logic [DW-1:0]  rsp_rdata;
  logic [3*CW-1:0] cfg_lead = '0;
  logic [3*CW-1:0] cfg_active = '0;
  logic [3*CW-1:0] cfg_trail = '0;
  logic [2:0]     cfg_wide = '0;
  logic [EAW-2:0] ext_addr;
  logic           ext_a0_wehi_n;
  logic [2:0]     ext_cs_n;
  logic           ext_rd_n;
  logic           ext_we_n;
  logic           ext_rnw;
  logic [DW-1:0]  ext_data_o;
  logic           ext_data_oe;
  logic [DW-1:0]  ext_data_i = '0;
  logic           ext_ready = 1'b1;
  logic           ext_bus_oe;
  logic           ext_hold_req = 1'b0;
  logic           ext_hold_ack;

  zbus_ctrl #(.CW(CW), .DW(DW), .EAW(EAW)) dut (.*);

  int nvec = 0;
  int nerr = 0;
  int lead_c[3];
  int act_c[3];
  int trl_c[3];
  bit wide_c[3];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int zone_of(input logic [21:0] a);
    if (a >= 22'h004000 && a < 22'h005000) return 0;
    if (a >= 22'h100000 && a < 22'h200000) return 1;
    if (a >= 22'h200000 && a < 22'h300000) return 2;
    return -1;
  endfunction

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < 3; i++) begin
      cfg_lead[i*CW +: CW]   = CW'(lead_c[i]);
      cfg_active[i*CW +: CW] = CW'(act_c[i]);
      cfg_trail[i*CW +: CW]  = CW'(trl_c[i]);
      cfg_wide[i]            = wide_c[i];
    end
  endtask

  task automatic run_acc(input logic [21:0] a, input bit wr, input logic [31:0] wd,
                         input logic [1:0] hw, input int k, input logic [31:0] rdv, input bit hold_mid);
    int z;
    int nl;
    int na;
    int nt;
    int guard;
    bit done;
    bit cs_bad;
    bit pin_bad;
    bit strb_bad;
    bit wd_mode;
    bit act;
    logic [2:0] exp_cs;
    logic [31:0] exp_rd;
    z = zone_of(a);
    nl = 0; na = 0; nt = 0; guard = 0; done = 0;
    cs_bad = 0; pin_bad = 0; strb_bad = 0;
    wd_mode = (z >= 0) ? wide_c[z] : 1'b0;
    exp_cs = (z >= 0) ? ~(3'b001 << z) : 3'b111;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_hwen = hw;
    ext_data_i = rdv; ext_ready = 1'b1;
    while (!done && guard < 200) begin
      @(negedge clk);
      req_valid = 1'b0;
      guard++;
      if (hold_mid && guard == 1) ext_hold_req = 1'b1;
      if (rsp_valid) begin
        done = 1;
      end else begin
        act = !ext_rd_n || !ext_we_n || (wd_mode && !ext_a0_wehi_n);
        if (ext_cs_n !== exp_cs) cs_bad = 1;
        if (ext_addr !== a[19:1]) pin_bad = 1;
        if (!wd_mode && ext_a0_wehi_n !== a[0]) pin_bad = 1;
        if (ext_rnw !== !wr || ext_data_oe !== wr) strb_bad = 1;
        if (act) begin
          na++;
          if (wr) begin
            if (ext_rd_n !== 1'b1) strb_bad = 1;
            if (wd_mode) begin
              if (ext_we_n !== !hw[0] || ext_a0_wehi_n !== !hw[1]) strb_bad = 1;
              if (ext_data_o !== wd) strb_bad = 1;
            end else begin
              if (ext_we_n !== 1'b0 || ext_data_o !== {16'h0, wd[15:0]}) strb_bad = 1;
            end
          end else begin
            if (ext_we_n !== 1'b1) strb_bad = 1;
            if (wd_mode && ext_a0_wehi_n !== 1'b1) strb_bad = 1;
          end
          ext_ready = (na > k);
        end else if (na == 0) begin
          nl++;
        end else begin
          nt++;
        end
      end
    end
    ext_ready = 1'b1;
    chk(done, "R11 response pulse arrives", 32'(done), 32'd1);
    if (z < 0) begin
      chk(guard == 1, "R9 unmapped response latency", 32'(guard), 32'd1);
      chk(rsp_err == 1'b1, "R9 unmapped error flag", 32'(rsp_err), 32'd1);
      chk(rsp_rdata == 32'h0, "R9 unmapped data zero", rsp_rdata, 32'h0);
      chk(ext_cs_n == 3'b111, "R9 no chip select", 32'(ext_cs_n), 32'h7);
    end else begin
      exp_rd = wr ? 32'h0 : (wd_mode ? rdv : {16'h0, rdv[15:0]});
      chk(!cs_bad, "R1 R2 zone chip select", 32'(z), 32'(z));
      chk(nl == atleast1(lead_c[z]), "R3 lead length", 32'(nl), 32'(atleast1(lead_c[z])));
      chk(na == ((atleast1(act_c[z]) > k + 1) ? atleast1(act_c[z]) : k + 1),
          "R4 strobe length", 32'(na), 32'((atleast1(act_c[z]) > k + 1) ? atleast1(act_c[z]) : k + 1));
      chk(nt == atleast1(trl_c[z]), "R5 trail length", 32'(nt), 32'(atleast1(trl_c[z])));
      chk(!pin_bad, wd_mode ? "R8 address pins" : "R7 address pins", 32'(pin_bad), 32'd0);
      chk(!strb_bad, wd_mode ? "R8 strobes and data" : "R7 R12 strobes and data", 32'(strb_bad), 32'd0);
      chk(rsp_err == 1'b0, "R6 no error", 32'(rsp_err), 32'd0);
      chk(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
      chk(ext_cs_n == 3'b111, "R5 chip select high at response", 32'(ext_cs_n), 32'h7);
    end
  endtask

  task automatic hold_seq(input bit already);
    if (!already) begin
      @(negedge clk);
      ext_hold_req = 1'b1;
      #1;
      chk(req_ready == 1'b0, "R11 ready low on hold request", 32'(req_ready), 32'd0);
    end
    @(negedge clk);
    chk(!ext_bus_oe && !ext_hold_ack, "R10 bus released before ack",
        {30'h0, ext_bus_oe, ext_hold_ack}, 32'h0);
    @(negedge clk);
    chk(ext_hold_ack && ext_cs_n == 3'b111, "R10 ack raised", 32'(ext_hold_ack), 32'd1);
    chk(req_ready == 1'b0, "R11 ready low while held", 32'(req_ready), 32'd0);
    ext_hold_req = 1'b0;
    #1;
    chk(ext_hold_ack == 1'b1, "R10 ack holds in same cycle", 32'(ext_hold_ack), 32'd1);
    @(negedge clk);
    chk(!ext_hold_ack && ext_bus_oe, "R10 ack dropped one cycle later", 32'(ext_hold_ack), 32'd0);
    chk(req_ready == 1'b1, "R11 ready returns", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [21:0] ra;
    void'($urandom(32'd2718));
    lead_c = '{1, 0, 3};
    act_c  = '{2, 3, 1};
    trl_c  = '{1, 2, 3};
    wide_c = '{0, 1, 0};
    apply_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ext_cs_n == 3'b111, "R2 reset chip selects high", 32'(ext_cs_n), 32'h7);
    chk(ext_rd_n && ext_we_n, "R2 reset strobes high", {30'h0, ext_rd_n, ext_we_n}, 32'h3);
    chk(req_ready == 1'b1 && !ext_hold_ack, "R11 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R11 reset no response", 32'(rsp_valid), 32'd0);

    // R1 boundaries of each zone
    run_acc(22'h004000, 0, 32'h0, 2'b00, 0, 32'hA5A5_1234, 0);
    run_acc(22'h004FFF, 0, 32'h0, 2'b00, 0, 32'h0000_BEEF, 0);
    run_acc(22'h100000, 0, 32'h0, 2'b00, 0, 32'hDEAD_BEEF, 0);
    run_acc(22'h1FFFFF, 0, 32'h0, 2'b00, 0, 32'h1357_9BDF, 0);
    run_acc(22'h200000, 0, 32'h0, 2'b00, 0, 32'hCAFE_F00D, 0);
    run_acc(22'h2FFFFF, 0, 32'h0, 2'b00, 0, 32'h8765_4321, 0);
    // R9 unmapped neighbours
    run_acc(22'h003FFF, 0, 32'h0, 2'b00, 0, 32'hFFFF_FFFF, 0);
    run_acc(22'h005000, 1, 32'h1111, 2'b01, 0, 32'hFFFF_FFFF, 0);
    run_acc(22'h0FFFFF, 0, 32'h0, 2'b00, 0, 32'hFFFF_FFFF, 0);
    run_acc(22'h300000, 0, 32'h0, 2'b00, 0, 32'hFFFF_FFFF, 0);
    // R7 R8 writes
    run_acc(22'h004001, 1, 32'h55AA_1234, 2'b00, 0, 32'h0, 0);
    run_acc(22'h100010, 1, 32'h55AA_1234, 2'b01, 0, 32'h0, 0);
    run_acc(22'h100011, 1, 32'h55AA_1234, 2'b10, 0, 32'h0, 0);
    run_acc(22'h100012, 1, 32'h55AA_1234, 2'b11, 0, 32'h0, 0);
    // R4 ready stalls below and beyond the minimum
    run_acc(22'h100020, 0, 32'h0, 2'b00, 1, 32'h0F0F_0F0F, 0);
    run_acc(22'h200021, 0, 32'h0, 2'b00, 5, 32'h0000_4242, 0);
    // R10 hold in idle, then during an access
    hold_seq(0);
    run_acc(22'h200100, 0, 32'h0, 2'b00, 3, 32'h0000_7777, 1);
    hold_seq(1);

    for (int it = 0; it < 80; it++) begin
      if (it % 10 == 0) begin
        for (int z = 0; z < 3; z++) begin
          lead_c[z] = int'($urandom % 6);
          act_c[z]  = int'($urandom % 6);
          trl_c[z]  = int'($urandom % 6);
          wide_c[z] = 1'($urandom % 2);
        end
        @(negedge clk);
        apply_cfg();
      end
      case ($urandom % 5)
        0: ra = 22'h004000 + 22'($urandom % 32'h1000);
        1: ra = 22'h100000 + 22'($urandom % 32'h100000);
        2: ra = 22'h200000 + 22'($urandom % 32'h100000);
        3: ra = 22'h300000 + 22'($urandom % 32'h100000);
        default: ra = 22'($urandom % 32'h4000);
      endcase
      run_acc(ra, 1'($urandom % 2), $urandom, 2'(1 + $urandom % 3),
              int'($urandom % 7), $urandom, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule